// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block sits on the CPU side of an interrupt controller and performs the hardware part of taking an interrupt. While the core is idle in the sequencer's view, any decode cycle that coincides with a pending, already-accepted interrupt request becomes an entry point. The instruction in decode is killed and never executes. Its address, the status register and the stack pointer are captured, together with the request's priority level, its vector number and the vector table base.

The sequencer then drives a single memory request port. It pushes the status word and after it the program counter onto a downward-growing stack of 4-byte words. It rewrites the 4-bit interrupt mask of the status register with the accepted level and acknowledges the arbiter. Finally it reads the handler address from the vector table and loads it straight into the program counter, with no delay slot. Each memory access holds until the memory returns ready. While the sequencer is busy the core is expected to stall, and new requests are not looked at.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `sp_we`, `sr_we`, `pc_we`, `irq_ack` and `dec_discard` are all low.
- R2: In an idle cycle with both `dec_valid` and `irq_req` high, `dec_discard` is high in that same cycle and `busy` is high from the next cycle. With either input low, nothing starts.
- R3: The first access after entry is a write (`mem_we`=1) of the captured status word to the captured stack pointer minus 4.
- R4: The second access is a write of the captured `dec_pc` to the captured stack pointer minus 8.
- R5: In the cycle each push completes (`mem_ready` high), `sp_we` pulses and `sp_out` equals that push's address, which is 4 below the previous stack pointer value.
- R6: In the cycle after the second push completes, `sr_we` and `irq_ack` are high for exactly one cycle. `sr_out` equals the captured status word with bits [7:4] replaced by the captured level and every other bit kept. No memory request is made in that cycle.
- R7: The next access is a read (`mem_we`=0) at the captured `vec_base` plus the captured vector number times 4.
- R8: In the cycle the vector read completes, `pc_we` is high and `pc_out` equals `mem_rdata`. `busy` is low in the following cycle.
- R9: While `mem_req` is high and `mem_ready` is low, the request, address, write data and direction stay unchanged into the next cycle.
- R10: While busy, changes on `dec_valid`, `irq_req`, `irq_level`, `irq_vec`, `sp_in`, `sr_in`, `dec_pc` and `vec_base` have no effect. All addresses and values use the ones captured at entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is in decode this cycle |
| dec_pc | input | 32 | Address of the instruction in decode |
| irq_req | input | 1 | Accepted interrupt pending |
| irq_level | input | 4 | Priority level of the accepted interrupt |
| irq_vec | input | VEC_W | Vector number of the accepted interrupt |
| vec_base | input | 32 | Vector table base address |
| sp_in | input | 32 | Current stack pointer |
| sr_in | input | 32 | Current status register |
| dec_discard | output | 1 | Kill the decoded instruction |
| busy | output | 1 | Entry sequence in progress |
| irq_ack | output | 1 | Acknowledge to the interrupt arbiter |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | 32 | New stack pointer value |
| sr_we | output | 1 | Status register write strobe |
| sr_out | output | 32 | New status register value |
| pc_we | output | 1 | Program counter write strobe |
| pc_out | output | 32 | Handler start address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory access completes this cycle |

## Verification
The bench builds the block with its default 8-bit vector number and mask field at bits [7:4]. With those values the largest vector (255, offset 1020) and the highest level (15) can be driven directly, and both sit next to a fully set status word. A stack pointer of zero makes the pushes wrap below address zero. Random ready stalls between zero and several cycles reach every wait state. The request and register inputs are re-randomised during each sequence, which checks that only the values captured at entry are used.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned LVL_W     = 4;
    localparam int unsigned WORD_LOG2 = 2;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PUSH_SR  = 3'd1,
        S_PUSH_PC  = 3'd2,
        S_SET_MASK = 3'd3,
        S_VEC_RD   = 3'd4
    } seq_state_e;

    typedef struct packed {
        word_t sr;
        word_t pc;
        word_t sp;
        word_t vbase;
        lvl_t  lvl;
    } entry_ctx_t;

    function automatic word_t word_step();
        return word_t'(1) << WORD_LOG2;
    endfunction

    function automatic word_t put_mask(word_t sr, lvl_t lvl, int unsigned lsb);
        word_t clr;
        clr = ~(word_t'({LVL_W{1'b1}}) << lsb);
        return (sr & clr) | (word_t'(lvl) << lsb);
    endfunction

endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dec_valid,
    input  logic       irq_req,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       take,
    output logic       push_done
);
    seq_state_e nxt;

    always_comb begin
        take      = (state == S_IDLE) && dec_valid && irq_req;
        push_done = ((state == S_PUSH_SR) || (state == S_PUSH_PC)) && mem_ready;
        nxt       = state;
        unique case (state)
            S_IDLE:     if (take)      nxt = S_PUSH_SR;
            S_PUSH_SR:  if (mem_ready) nxt = S_PUSH_PC;
            S_PUSH_PC:  if (mem_ready) nxt = S_SET_MASK;
            S_SET_MASK:                nxt = S_VEC_RD;
            S_VEC_RD:   if (mem_ready) nxt = S_IDLE;
            default:                   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    p_take_starts_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> (state == S_PUSH_SR));
    p_mask_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_SET_MASK) |=> (state == S_VEC_RD));
endmodule

// File: rtl/irq_entry_ctx.sv
module irq_entry_ctx
    import irq_entry_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             push_done,
    input  word_t            dec_pc,
    input  word_t            sr_in,
    input  word_t            sp_in,
    input  word_t            vec_base,
    input  lvl_t             irq_level,
    input  logic [VEC_W-1:0] irq_vec,
    output entry_ctx_t       ctx,
    output logic [VEC_W-1:0] vec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
            vec <= '0;
        end else if (take) begin
            ctx.sr    <= sr_in;
            ctx.pc    <= dec_pc;
            ctx.sp    <= sp_in;
            ctx.vbase <= vec_base;
            ctx.lvl   <= irq_level;
            vec       <= irq_vec;
        end else if (push_done) begin
            ctx.sp <= ctx.sp - word_step();
        end
    end

    p_sp_step_r5: assert property (@(posedge clk) disable iff (rst)
        (push_done && !take) |=> (ctx.sp == $past(ctx.sp) - word_step()));
endmodule

// File: rtl/irq_entry_port.sv
module irq_entry_port
    import irq_entry_pkg::*;
#(
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned MASK_LSB = 4
) (
    input  seq_state_e       state,
    input  entry_ctx_t       ctx,
    input  logic [VEC_W-1:0] vec,
    input  logic             mem_ready,
    input  word_t            mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output word_t            mem_addr,
    output word_t            mem_wdata,
    output logic             sp_we,
    output word_t            sp_out,
    output logic             sr_we,
    output word_t            sr_out,
    output logic             pc_we,
    output word_t            pc_out,
    output logic             irq_ack
);
    localparam int unsigned PAD_W = XLEN - VEC_W;

    word_t push_addr;
    word_t vec_addr;

    always_comb begin
        push_addr = ctx.sp - word_step();
        vec_addr  = ctx.vbase + ({{PAD_W{1'b0}}, vec} << WORD_LOG2);

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = push_addr;
        mem_wdata = ctx.sr;
        sp_we     = 1'b0;
        sp_out    = push_addr;
        sr_we     = 1'b0;
        sr_out    = put_mask(ctx.sr, ctx.lvl, MASK_LSB);
        pc_we     = 1'b0;
        pc_out    = mem_rdata;
        irq_ack   = 1'b0;

        unique case (state)
            S_PUSH_SR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                sp_we   = mem_ready;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ctx.pc;
                sp_we     = mem_ready;
            end
            S_SET_MASK: begin
                sr_we   = 1'b1;
                irq_ack = 1'b1;
            end
            S_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
                pc_we    = mem_ready;
            end
            default: ;
        endcase
    end

    always_comb begin
        a_ack_with_sr_r6: assert (irq_ack == sr_we);
        a_no_req_in_mask_r6: assert (!(sr_we && mem_req));
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned MASK_LSB = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [31:0]      dec_pc,
    input  logic             irq_req,
    input  logic [3:0]       irq_level,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [31:0]      vec_base,
    input  logic [31:0]      sp_in,
    input  logic [31:0]      sr_in,
    output logic             dec_discard,
    output logic             busy,
    output logic             irq_ack,
    output logic             sp_we,
    output logic [31:0]      sp_out,
    output logic             sr_we,
    output logic [31:0]      sr_out,
    output logic             pc_we,
    output logic [31:0]      pc_out,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ready
);
    seq_state_e       state;
    logic             take;
    logic             push_done;
    entry_ctx_t       ctx;
    logic [VEC_W-1:0] vec;

    irq_entry_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .irq_req   (irq_req),
        .mem_ready (mem_ready),
        .state     (state),
        .take      (take),
        .push_done (push_done)
    );

    irq_entry_ctx #(.VEC_W(VEC_W)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .push_done (push_done),
        .dec_pc    (dec_pc),
        .sr_in     (sr_in),
        .sp_in     (sp_in),
        .vec_base  (vec_base),
        .irq_level (irq_level),
        .irq_vec   (irq_vec),
        .ctx       (ctx),
        .vec       (vec)
    );

    irq_entry_port #(.VEC_W(VEC_W), .MASK_LSB(MASK_LSB)) u_port (
        .state     (state),
        .ctx       (ctx),
        .vec       (vec),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp_we     (sp_we),
        .sp_out    (sp_out),
        .sr_we     (sr_we),
        .sr_out    (sr_out),
        .pc_we     (pc_we),
        .pc_out    (pc_out),
        .irq_ack   (irq_ack)
    );

    assign dec_discard = take;
    assign busy        = (state != S_IDLE);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !sp_we && !sr_we && !pc_we);
    p_hold_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr)
                                    && $stable(mem_we) && $stable(mem_wdata));
    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> !busy);
    p_no_reentry_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dec_discard);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int VEC_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             dec_valid = 0, irq_req = 0, mem_ready = 0;
    logic [31:0]      dec_pc = 0, vec_base = 0, sp_in = 0, sr_in = 0, mem_rdata = 0;
    logic [3:0]       irq_level = 0;
    logic [VEC_W-1:0] irq_vec = 0;
    logic             dec_discard, busy, irq_ack, sp_we, sr_we, pc_we, mem_req, mem_we;
    logic [31:0]      sp_out, sr_out, pc_out, mem_addr, mem_wdata;

    irq_entry_seq #(.VEC_W(VEC_W), .MASK_LSB(4)) u_irq_entry_seq (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model of the requirements
    int          m_st = 0;  // 0 idle,1 push sr,2 push pc,3 mask,4 vector
    logic [31:0] m_sp, m_sr, m_pc, m_vb;
    logic [3:0]  m_lvl;
    logic [VEC_W-1:0] m_vec;

    function automatic logic [31:0] exp_sr(logic [31:0] s, logic [3:0] l);
        return {s[31:8], l, s[3:0]};
    endfunction

    function automatic logic [31:0] exp_vaddr(logic [31:0] b, logic [VEC_W-1:0] v);
        return b + 32'(v) * 32'd4;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic t;
        t = (m_st == 0) && dec_valid && irq_req;
        chk("R2 dec_discard", 32'(dec_discard), 32'(t));
        chk("R2 busy", 32'(busy), 32'(m_st != 0));
        chk("R6 irq_ack", 32'(irq_ack), 32'(m_st == 3));
        chk("R6 sr_we", 32'(sr_we), 32'(m_st == 3));
        chk("R6 mem_req", 32'(mem_req), 32'(m_st == 1 || m_st == 2 || m_st == 4));
        chk("R5 sp_we", 32'(sp_we), 32'((m_st == 1 || m_st == 2) && mem_ready));
        chk("R8 pc_we", 32'(pc_we), 32'(m_st == 4 && mem_ready));
        case (m_st)
            1: begin
                chk("R3 mem_we", 32'(mem_we), 32'd1);
                chk("R3 mem_addr", mem_addr, m_sp - 32'd4);
                chk("R3 mem_wdata", mem_wdata, m_sr);
                if (mem_ready) chk("R5 sp_out", sp_out, m_sp - 32'd4);
            end
            2: begin
                chk("R4 mem_we", 32'(mem_we), 32'd1);
                chk("R4 mem_addr", mem_addr, m_sp - 32'd4);
                chk("R4 mem_wdata", mem_wdata, m_pc);
                if (mem_ready) chk("R5 sp_out", sp_out, m_sp - 32'd4);
            end
            3: chk("R6 sr_out", sr_out, exp_sr(m_sr, m_lvl));
            4: begin
                chk("R7 mem_we", 32'(mem_we), 32'd0);
                chk("R7 mem_addr", mem_addr, exp_vaddr(m_vb, m_vec));
                if (mem_ready) chk("R8 pc_out", pc_out, mem_rdata);
            end
            default: ;
        endcase
    endtask

    task automatic model_step();
        case (m_st)
            0: if (dec_valid && irq_req) begin
                m_st = 1; m_sp = sp_in; m_sr = sr_in; m_pc = dec_pc;
                m_vb = vec_base; m_lvl = irq_level; m_vec = irq_vec;
            end
            1, 2: if (mem_ready) begin m_sp = m_sp - 32'd4; m_st = m_st + 1; end
            3: m_st = 4;
            4: if (mem_ready) m_st = 0;
            default: m_st = 0;
        endcase
    endtask

    // one cycle: drive after the falling edge, check, advance model
    task automatic cycle(bit dv, bit rq, logic [3:0] lv, logic [VEC_W-1:0] vc,
                         logic [31:0] sp, logic [31:0] sr, logic [31:0] pc,
                         logic [31:0] vb, bit rdy);
        @(negedge clk);
        dec_valid = dv; irq_req = rq; irq_level = lv; irq_vec = vc;
        sp_in = sp; sr_in = sr; dec_pc = pc; vec_base = vb;
        mem_ready = rdy; mem_rdata = $urandom;
        #2;
        check_outputs();
        model_step();
    endtask

    task automatic rand_cycle(int rdy_pct);
        cycle($urandom_range(1) == 1, $urandom_range(99) < 40, 4'($urandom),
              VEC_W'($urandom), $urandom, $urandom, $urandom, $urandom,
              $urandom_range(99) < rdy_pct);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 strobes", 32'({sp_we, sr_we, pc_we, irq_ack, dec_discard}), 0);

        // R2 no start without request / without decode
        cycle(1, 0, 4'd3, 8'd1, 32'h100, 32'h0, 32'h40, 32'h0, 1);
        cycle(0, 1, 4'd3, 8'd1, 32'h100, 32'h0, 32'h40, 32'h0, 1);

        // directed: level 15, vector 255, sp wrap at 0, full SR, zero wait
        cycle(1, 1, 4'hF, 8'hFF, 32'h0, 32'hFFFF_FF0F, 32'h0000_1234, 32'hFFFF_FF00, 1);
        repeat (5) cycle(1, 1, 4'h0, 8'h00, 32'h5, 32'h0, 32'h0, 32'h0, 1);

        // directed: long waits on every access, inputs changing meanwhile (R9, R10)
        cycle(1, 1, 4'h1, 8'h02, 32'h8000, 32'h0000_00F0, 32'h0C00, 32'h1000, 0);
        repeat (30) rand_cycle(15);

        // constrained random
        repeat (4000) rand_cycle(60);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule